// File: doc/BRIEF.md
# Subclass-Sorted I/O Interrupt Pending Queue

This block keeps pending I/O interrupt requests sorted into eight subclasses and releases them to a consumer in a fixed priority order. Each request carries a subchannel id, a subchannel number, a parameter word and an interrupt word. The subclass is read from the interrupt word. Within one subclass the newest request leaves first. The consumer presents an enable mask with each dequeue and receives one entry, or a miss, one cycle later.

The block can also purge every stored request that matches a given id and number. The purge walks all subclasses in parallel, one stored slot per cycle. Next to the I/O lists the block keeps two simpler pending sources. The first is a service signal, whose parameters are merged by OR into one word. The second is a machine-check / channel-report flag. A summary of the per-subclass pending bits, together with an enabled-I/O indication, lets the consumer decide whether a dequeue is worth issuing.

Top module: `subclass_irq_queue`

## Requirements
- R1: The subclass of an injected request is bits 29:27 of its interrupt word. Bit i of `io_pending` belongs to subclass i. The stored word, parameter, id and number are returned unchanged on dequeue.
- R2: Within one subclass, dequeue returns the most recently accepted entry first (last-in-first-out).
- R3: A dequeue returns the head of the lowest-numbered subclass that is non-empty and enabled. `class_en[7-i]` enables subclass i. When no subclass qualifies, `rsp_hit` is 0.
- R4: `rsp_valid` is high for exactly the one cycle that follows an accepted dequeue.
- R5: A subclass's pending bit rises on an accepted inject and falls only when its list becomes empty. `has_io` is the OR of the pending bits whose subclass is enabled in `class_en`.
- R6: Each subclass holds DEPTH entries (default 4). An inject into a full subclass is dropped, and it sets `overflow`, which stays high until reset.
- R7: An accepted purge removes every entry whose id and number both match, in all subclasses, and keeps the remaining entries in their order. When any I/O is pending, `purge_busy` is high for DEPTH cycles, and during that time `inj_ready`, `deq_ready` and `purge_ready` are low.
- R8: A purge accepted while no I/O is pending completes without raising `purge_busy` and changes nothing.
- R9: `svc_set` ORs `svc_parm_in` into `svc_parm` and sets `svc_pending`. `svc_take` clears both. If set and take come in the same cycle, the new parameter alone remains and the pending bit stays set.
- R10: `mck_set` sets `mck_pending` and `mck_take` clears it. If both come in the same cycle, the flag stays set.
- R11: Reset empties every subclass and clears every pending bit, `overflow`, `svc_parm` and `rsp_valid`.
- R12: `inj_ready` is low in any cycle in which `deq_valid` is high, so that inject and dequeue never act in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_valid | input | 1 | Inject request |
| inj_ready | output | 1 | Inject may be accepted |
| inj_id | input | 16 | Subchannel id |
| inj_nr | input | 16 | Subchannel number |
| inj_parm | input | 32 | Interrupt parameter |
| inj_word | input | 32 | Interrupt word, subclass in bits 29:27 |
| deq_valid | input | 1 | Dequeue request |
| deq_ready | output | 1 | Dequeue may be accepted |
| class_en | input | 8 | Subclass enable mask, bit 7 for subclass 0 |
| rsp_valid | output | 1 | Dequeue response valid |
| rsp_hit | output | 1 | Response carries an entry |
| rsp_id | output | 16 | Returned id |
| rsp_nr | output | 16 | Returned number |
| rsp_parm | output | 32 | Returned parameter |
| rsp_word | output | 32 | Returned interrupt word |
| purge_valid | input | 1 | Purge request |
| purge_ready | output | 1 | Purge may be accepted |
| purge_id | input | 16 | Id to purge |
| purge_nr | input | 16 | Number to purge |
| purge_busy | output | 1 | Purge walk in progress |
| svc_set | input | 1 | Inject service signal |
| svc_parm_in | input | 32 | Service parameter to merge |
| svc_take | input | 1 | Consume service signal |
| svc_pending | output | 1 | Service signal pending |
| svc_parm | output | 32 | Merged service parameter |
| mck_set | input | 1 | Inject machine-check / channel report |
| mck_take | input | 1 | Consume machine-check |
| mck_pending | output | 1 | Machine-check pending |
| io_pending | output | 8 | Per-subclass pending bits |
| has_io | output | 1 | Some enabled subclass is pending |
| overflow | output | 1 | Sticky: an inject was dropped |

## Verification
The hardest state to reach is a purge that has to compact the survivors inside more than one subclass at once, with a match below a non-match in the same stack. It also has to leave one subclass populated and another untouched. The stimulus builds this state by injecting interleaved matching and non-matching entries into two subclasses before the purge. It then drains the lists under a full mask, so the surviving order and the busy length both show at the ports. Overflow is reached by over-filling a single subclass, and it is then confirmed that the dropped request never emerges.

// File: rtl/irqq_pkg.sv
package irqq_pkg;
   localparam int ID_W      = 16;
   localparam int NR_W      = 16;
   localparam int PARM_W    = 32;
   localparam int WORD_W    = 32;
   localparam int NUM_CLASS = 8;
   localparam int CLS_W     = $clog2(NUM_CLASS);
   localparam int CLS_LSB   = 27;

   typedef struct packed {
      logic [ID_W-1:0]   id;
      logic [NR_W-1:0]   nr;
      logic [PARM_W-1:0] parm;
      logic [WORD_W-1:0] word;
   } irq_ent_t;
endpackage

// File: rtl/irqq_stack.sv
module irqq_stack
   import irqq_pkg::*;
#(
   parameter int DEPTH  = 4,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  irq_ent_t         push_ent,
   input  logic             pop,
   input  logic             scan_on,
   input  logic             scan_first,
   input  logic             scan_last,
   input  logic [IDX_W-1:0] scan_idx,
   input  logic [ID_W-1:0]  key_id,
   input  logic [NR_W-1:0]  key_nr,
   output irq_ent_t         head,
   output logic [CNT_W-1:0] count,
   output logic             full
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("irqq_stack: DEPTH must be at least 2");
      end
   endgenerate

   irq_ent_t         slot [DEPTH];
   logic [CNT_W-1:0] cnt, wr_ptr, wbase, wnext;
   logic             in_range, keep;

   assign in_range = CNT_W'(scan_idx) < cnt;
   assign keep     = in_range && !((slot[scan_idx].id == key_id) &&
                                   (slot[scan_idx].nr == key_nr));
   assign wbase    = scan_first ? '0 : wr_ptr;
   assign wnext    = wbase + CNT_W'(keep);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         wr_ptr <= '0;
      end else if (scan_on) begin
         wr_ptr <= wnext;
         if (scan_last) cnt <= wnext;
      end else if (push) begin
         cnt <= cnt + 1'b1;
      end else if (pop) begin
         cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (scan_on) begin
         if (keep) slot[IDX_W'(wbase)] <= slot[scan_idx];
      end else if (push) begin
         slot[IDX_W'(cnt)] <= push_ent;
      end
   end

   assign head  = slot[IDX_W'(cnt - 1'b1)];
   assign count = cnt;
   assign full  = (cnt == CNT_W'(DEPTH));

   assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt != '0));
   assert_push_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt < CNT_W'(DEPTH)));
   assert_pend_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnt != '0) |-> $past(push));
   assert_scan_no_grow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_on && scan_last) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/irqq_pick.sv
module irqq_pick #(
   parameter int N      = 8,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     avail,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (avail[i]) idx = IDX_W'(i);
      end
      any   = |avail;
      grant = any ? (N'(1) << idx) : '0;
   end

   always_comb begin
      assert_grant_onehot_R3: assert ($onehot0(grant));
      assert_grant_avail_R3: assert ((grant & ~avail) == '0);
   end
endmodule

// File: rtl/subclass_irq_queue.sv
module subclass_irq_queue
   import irqq_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inj_valid,
   output logic              inj_ready,
   input  logic [ID_W-1:0]   inj_id,
   input  logic [NR_W-1:0]   inj_nr,
   input  logic [PARM_W-1:0] inj_parm,
   input  logic [WORD_W-1:0] inj_word,
   input  logic              deq_valid,
   output logic              deq_ready,
   input  logic [NUM_CLASS-1:0] class_en,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [ID_W-1:0]   rsp_id,
   output logic [NR_W-1:0]   rsp_nr,
   output logic [PARM_W-1:0] rsp_parm,
   output logic [WORD_W-1:0] rsp_word,
   input  logic              purge_valid,
   output logic              purge_ready,
   input  logic [ID_W-1:0]   purge_id,
   input  logic [NR_W-1:0]   purge_nr,
   output logic              purge_busy,
   input  logic              svc_set,
   input  logic [PARM_W-1:0] svc_parm_in,
   input  logic              svc_take,
   output logic              svc_pending,
   output logic [PARM_W-1:0] svc_parm,
   input  logic              mck_set,
   input  logic              mck_take,
   output logic              mck_pending,
   output logic [NUM_CLASS-1:0] io_pending,
   output logic              has_io,
   output logic              overflow
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (CLS_LSB + CLS_W > WORD_W) begin : g_bad_word
         $error("subclass_irq_queue: subclass field outside interrupt word");
      end
   endgenerate

   logic                 busy;
   logic [IDX_W-1:0]     p_idx;
   logic [ID_W-1:0]      key_id;
   logic [NR_W-1:0]      key_nr;
   logic [CLS_W-1:0]     inj_cls;
   logic                 inj_fire, deq_fire, purge_fire;
   logic [NUM_CLASS-1:0] full, en_vec, avail, grant;
   logic [CLS_W-1:0]     pick_idx;
   logic                 pick_any;
   irq_ent_t             heads [NUM_CLASS];
   irq_ent_t             new_ent, rsp_ent;

   assign inj_cls     = inj_word[CLS_LSB +: CLS_W];
   assign inj_ready   = !busy && !deq_valid;
   assign deq_ready   = !busy;
   assign purge_ready = !busy;
   assign inj_fire    = inj_valid && inj_ready;
   assign deq_fire    = deq_valid && deq_ready;
   assign purge_fire  = purge_valid && purge_ready;
   assign new_ent     = '{id: inj_id, nr: inj_nr, parm: inj_parm, word: inj_word};

   for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
      logic [CNT_W-1:0] cnt;
      assign en_vec[c] = class_en[NUM_CLASS-1-c];

      irqq_stack #(.DEPTH(DEPTH)) u_stack (
         .clk        (clk),
         .rst_n      (rst_n),
         .push       (inj_fire && (inj_cls == CLS_W'(c)) && !full[c]),
         .push_ent   (new_ent),
         .pop        (deq_fire && grant[c]),
         .scan_on    (busy),
         .scan_first (p_idx == '0),
         .scan_last  (p_idx == IDX_W'(DEPTH - 1)),
         .scan_idx   (p_idx),
         .key_id     (key_id),
         .key_nr     (key_nr),
         .head       (heads[c]),
         .count      (cnt),
         .full       (full[c])
      );
      assign io_pending[c] = (cnt != '0);
   end

   assign avail  = io_pending & en_vec;
   assign has_io = |avail;

   irqq_pick #(.N(NUM_CLASS)) u_pick (
      .avail (avail),
      .grant (grant),
      .idx   (pick_idx),
      .any   (pick_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         p_idx  <= '0;
         key_id <= '0;
         key_nr <= '0;
      end else if (busy) begin
         p_idx <= p_idx + 1'b1;
         if (p_idx == IDX_W'(DEPTH - 1)) busy <= 1'b0;
      end else if (purge_fire && (|io_pending)) begin
         busy   <= 1'b1;
         p_idx  <= '0;
         key_id <= purge_id;
         key_nr <= purge_nr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_ent   <= '0;
      end else begin
         rsp_valid <= deq_fire;
         if (deq_fire) begin
            rsp_hit <= pick_any;
            rsp_ent <= pick_any ? heads[pick_idx] : '0;
         end
      end
   end

   assign rsp_id   = rsp_ent.id;
   assign rsp_nr   = rsp_ent.nr;
   assign rsp_parm = rsp_ent.parm;
   assign rsp_word = rsp_ent.word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) overflow <= 1'b0;
      else if (inj_fire && full[inj_cls]) overflow <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_pending <= 1'b0;
         svc_parm    <= '0;
      end else if (svc_take) begin
         svc_pending <= svc_set;
         svc_parm    <= svc_set ? svc_parm_in : '0;
      end else if (svc_set) begin
         svc_pending <= 1'b1;
         svc_parm    <= svc_parm | svc_parm_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mck_pending <= 1'b0;
      else if (mck_set) mck_pending <= 1'b1;
      else if (mck_take) mck_pending <= 1'b0;
   end

   assert_rsp_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      deq_fire |=> rsp_valid);
   assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !deq_fire |=> !rsp_valid);
   assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      purge_busy |-> (!inj_ready && !deq_ready && !purge_ready));
   assert_has_io_R5: assert property (@(posedge clk) disable iff (!rst_n)
      has_io |-> (|io_pending));
   assert_svc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(svc_pending) |-> $past(svc_take));
   assert_mck_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mck_set |=> mck_pending);
   assert_no_inj_deq_R12: assert property (@(posedge clk) disable iff (!rst_n)
      deq_valid |-> !inj_ready);

   assign purge_busy = busy;
endmodule

// File: tb/subclass_irq_queue_bench.sv
`timescale 1ns/1ps
module subclass_irq_queue_bench;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inj_valid = 0, deq_valid = 0, purge_valid = 0;
   logic        svc_set = 0, svc_take = 0, mck_set = 0, mck_take = 0;
   logic [15:0] inj_id = 0, inj_nr = 0, purge_id = 0, purge_nr = 0;
   logic [31:0] inj_parm = 0, inj_word = 0, svc_parm_in = 0;
   logic [7:0]  class_en = 8'hFF;
   logic        inj_ready, deq_ready, purge_ready, purge_busy;
   logic        rsp_valid, rsp_hit, svc_pending, mck_pending, has_io, overflow;
   logic [15:0] rsp_id, rsp_nr;
   logic [31:0] rsp_parm, rsp_word, svc_parm;
   logic [7:0]  io_pending;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   subclass_irq_queue #(.DEPTH(DEPTH)) u_subclass_irq_queue (
      .clk(clk), .rst_n(rst_n),
      .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_id(inj_id),
      .inj_nr(inj_nr), .inj_parm(inj_parm), .inj_word(inj_word),
      .deq_valid(deq_valid), .deq_ready(deq_ready), .class_en(class_en),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_id(rsp_id),
      .rsp_nr(rsp_nr), .rsp_parm(rsp_parm), .rsp_word(rsp_word),
      .purge_valid(purge_valid), .purge_ready(purge_ready),
      .purge_id(purge_id), .purge_nr(purge_nr), .purge_busy(purge_busy),
      .svc_set(svc_set), .svc_parm_in(svc_parm_in), .svc_take(svc_take),
      .svc_pending(svc_pending), .svc_parm(svc_parm),
      .mck_set(mck_set), .mck_take(mck_take), .mck_pending(mck_pending),
      .io_pending(io_pending), .has_io(has_io), .overflow(overflow)
   );

   // inject table: {subclass, id}; expected dequeue ids under a full mask, 0 = miss
   localparam logic [18:0] INJ_TBL [6] = '{
      {3'd3, 16'hA001}, {3'd3, 16'hA002}, {3'd5, 16'hB001},
      {3'd0, 16'hC001}, {3'd3, 16'hA003}, {3'd7, 16'hD001}
   };
   localparam logic [15:0] EXP_TBL [7] = '{
      16'hC001, 16'hA003, 16'hA002, 16'hA001, 16'hB001, 16'hD001, 16'h0000
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic inject(input logic [2:0] cls, input logic [15:0] id, input logic [15:0] nr);
      @(negedge clk);
      inj_valid = 1; inj_id = id; inj_nr = nr;
      inj_parm = {16'h5A00, id}; inj_word = {2'b00, cls, 27'h0000123};
      @(negedge clk);
      inj_valid = 0;
   endtask

   task automatic dequeue(input logic [7:0] mask);
      @(negedge clk);
      deq_valid = 1; class_en = mask;
      @(negedge clk);
      deq_valid = 0;
   endtask

   task automatic purge(input logic [15:0] id, input logic [15:0] nr, output int cyc);
      @(negedge clk);
      purge_valid = 1; purge_id = id; purge_nr = nr;
      @(negedge clk);
      purge_valid = 0;
      cyc = 0;
      while (purge_busy && cyc < 100) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   initial begin
      #200000;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk("R11 io_pending after reset", 32'(io_pending), 0);
      chk("R11 overflow after reset", 32'(overflow), 0);
      chk("R11 rsp_valid after reset", 32'(rsp_valid), 0);

      // R1/R2/R3 table walk
      for (int k = 0; k < 6; k++) inject(INJ_TBL[k][18:16], INJ_TBL[k][15:0], 16'h0001);
      chk("R1 R5 pending vector", 32'(io_pending), 32'h00A9);
      for (int k = 0; k < 7; k++) begin
         dequeue(8'hFF);
         chk("R4 rsp_valid", 32'(rsp_valid), 1);
         chk("R3 rsp_hit", 32'(rsp_hit), (EXP_TBL[k] != 0) ? 1 : 0);
         if (EXP_TBL[k] != 0) begin
            chk("R2 R3 order id", 32'(rsp_id), 32'(EXP_TBL[k]));
            chk("R1 parm returned", rsp_parm, {16'h5A00, EXP_TBL[k]});
         end
      end
      @(negedge clk);
      chk("R4 rsp_valid single cycle", 32'(rsp_valid), 0);
      chk("R5 pending empty after drain", 32'(io_pending), 0);

      // R3/R5 mask: subclass i enabled by bit 7-i
      inject(3'd2, 16'h0022, 16'h0002);
      inject(3'd6, 16'h0066, 16'h0006);
      @(negedge clk); class_en = 8'h20; #1;
      chk("R5 has_io subclass 2 enabled", 32'(has_io), 1);
      class_en = 8'h01; #1;
      chk("R5 has_io subclass 7 only", 32'(has_io), 0);
      dequeue(8'h02);
      chk("R3 masked pick id", 32'(rsp_id), 32'h0066);
      chk("R1 word returned", rsp_word, {2'b00, 3'd6, 27'h0000123});
      dequeue(8'h00);
      chk("R3 empty mask misses", 32'(rsp_hit), 0);
      chk("R3 miss leaves pending", 32'(io_pending), 32'h0004);
      dequeue(8'hFF);
      chk("R3 remaining id", 32'(rsp_id), 32'h0022);

      // R6 overflow
      for (int k = 0; k <= DEPTH; k++) inject(3'd1, 16'(16'h0100 + k), 16'h0001);
      chk("R6 overflow set", 32'(overflow), 1);
      for (int k = DEPTH - 1; k >= 0; k--) begin
         dequeue(8'hFF);
         chk("R6 kept entries", 32'(rsp_id), 32'(16'h0100 + k));
      end
      dequeue(8'hFF);
      chk("R6 dropped entry absent", 32'(rsp_hit), 0);
      chk("R6 overflow sticky", 32'(overflow), 1);

      // R7 purge across two subclasses
      inject(3'd1, 16'h0005, 16'h0001);
      inject(3'd1, 16'h0006, 16'h0001);
      inject(3'd4, 16'h0007, 16'h0001);
      inject(3'd4, 16'h0005, 16'h0001);
      inject(3'd4, 16'h0005, 16'h0009);
      @(negedge clk);
      purge_valid = 1; purge_id = 16'h0005; purge_nr = 16'h0001;
      @(negedge clk);
      purge_valid = 0;
      chk("R7 busy blocks inject", 32'(inj_ready), 0);
      chk("R7 busy blocks purge", 32'(purge_ready), 0);
      cyc = 0;
      while (purge_busy && cyc < 100) begin cyc++; @(negedge clk); end
      chk("R7 busy cycles", cyc, DEPTH);
      chk("R7 pending after purge", 32'(io_pending), 32'h0012);
      dequeue(8'hFF);
      chk("R7 survivor subclass 1", 32'(rsp_id), 32'h0006);
      dequeue(8'hFF);
      chk("R7 non-matching nr survives", {rsp_id, rsp_nr}, 32'h00050009);
      dequeue(8'hFF);
      chk("R7 survivor subclass 4", 32'(rsp_id), 32'h0007);
      dequeue(8'hFF);
      chk("R7 nothing left", 32'(rsp_hit), 0);

      // R8 purge with nothing pending
      purge(16'h0005, 16'h0001, cyc);
      chk("R8 empty purge no busy", cyc, 0);
      chk("R8 still empty", 32'(io_pending), 0);

      // R9 service merge
      @(negedge clk); svc_set = 1; svc_parm_in = 32'h0000_000F;
      @(negedge clk); svc_parm_in = 32'h0000_00F0;
      @(negedge clk); svc_set = 0;
      chk("R9 merged parm", svc_parm, 32'h0000_00FF);
      chk("R9 pending", 32'(svc_pending), 1);
      svc_take = 1;
      @(negedge clk); svc_take = 0;
      chk("R9 take clears pending", 32'(svc_pending), 0);
      chk("R9 take zeroes parm", svc_parm, 0);
      svc_set = 1; svc_take = 1; svc_parm_in = 32'h1;
      @(negedge clk); svc_set = 0; svc_take = 0;
      chk("R9 set with take", {svc_parm[30:0], svc_pending}, 32'h3);

      // R10 machine check
      mck_set = 1;
      @(negedge clk); mck_set = 0;
      chk("R10 set", 32'(mck_pending), 1);
      mck_take = 1;
      @(negedge clk); mck_take = 0;
      chk("R10 take", 32'(mck_pending), 0);
      mck_set = 1; mck_take = 1;
      @(negedge clk); mck_set = 0; mck_take = 0;
      chk("R10 set wins over take", 32'(mck_pending), 1);

      // R12 dequeue request blocks inject
      deq_valid = 1; #1;
      chk("R12 inj_ready low with deq_valid", 32'(inj_ready), 0);
      @(negedge clk); deq_valid = 0;

      // R11 reset mid-run
      inject(3'd2, 16'h0abc, 16'h0001);
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1;
      @(negedge clk);
      chk("R11 pending cleared", 32'(io_pending), 0);
      chk("R11 overflow cleared", 32'(overflow), 0);
      chk("R11 svc/mck cleared", {svc_parm[29:0], svc_pending, mck_pending}, 0);
      dequeue(8'hFF);
      chk("R11 lists emptied", 32'(rsp_hit), 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule